// File: doc/BRIEF.md
# Serial ADC Conversion Front End

This block is the digital control logic in front of a four-channel serial analog-to-digital converter. It runs on a fast system clock and oversamples an external serial clock, a two-bit channel address and an active-high enable through two-flop synchronizers. A falling edge of the serial clock wakes the block, latches the channel and opens a resolution-select window. Each further falling edge inside that window gives up one bit of resolution. When the window closes, a one-cycle start pulse goes to the converter together with the channel and the chosen resolution.

While the conversion runs, the serial data output is held low so a host can treat it as a busy line. After the converter returns its left-aligned result, each later falling edge of the serial clock presents the next result bit, most significant bit first. One more edge after the last bit drops the line low and returns the block to sleep. Pulling the enable low at any time abandons the cycle.

Top module: `sadc_front`

## Requirements
- R1: While asleep with enable high, a synchronized falling edge of `sck_in` starts a conversion cycle. With enable low, serial-clock edges start nothing.
- R2: The address on `addr_in` is captured on the starting edge and stays on `conv_chan` for the whole conversion (00 selects input 1, 01 input 2, 10 input 3, 11 input 4).
- R3: Each falling edge inside the window of `WIN_CYCLES` system cycles after the start edge lowers the resolution by one bit, from 16 down to a floor of 10. A seventh and later edge leaves it at 10.
- R4: Falling edges after the window closes and before `conv_done` are ignored. They neither change the resolution nor consume result bits.
- R5: `sdo` stays low from the start edge until the first readout edge after `conv_done`.
- R6: After `conv_done`, each falling edge drives the next bit of `conv_result` onto `sdo`, starting at bit 15. Exactly `conv_res` bits are sent.
- R7: The falling edge after the last result bit drives `sdo` low and returns the block to sleep. The next edge starts a new conversion.
- R8: Enable low clears any conversion or readout, forces `sdo` low and puts the block to sleep. A `conv_done` that arrives while asleep is ignored.
- R9: `conv_start` is a single-cycle pulse issued when the window closes, with `conv_res` and `conv_chan` valid in that cycle.
- R10: After reset, `sdo` and `conv_start` are low and the block is asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | External serial clock, idle high |
| addr_in | input | 2 | Channel address |
| en_in | input | 1 | Enable; low aborts and sleeps |
| sdo | output | 1 | Serial data; low while busy |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_res | output | RW | Selected resolution in bits |
| conv_chan | output | 2 | Latched channel |
| conv_done | input | 1 | Conversion-complete pulse |
| conv_result | input | 16 | Left-aligned conversion result |

## Verification
Several checks run on every cycle. The assertions confirm that the data line is low whenever a conversion is in progress, that the start pulse lasts one cycle and carries a resolution inside the 10 to 16 range, that the channel does not move during a conversion, and that a low enable empties the block on the next cycle. The rest depends on edge counts and timing, so only the bench scenarios can show it. These cover the exact resolution reached after zero, three, six and seven extra edges, the channel decoding, the MSB-first order of the bits and their count, late edges being ignored, the return to sleep after readout, and recovery after an abort in the middle of a readout.

// File: rtl/sadc_front.sv
module sadc_front #(
  parameter int RES_FULL   = 16,
  parameter int MAX_CUT    = 6,
  parameter int WIN_CYCLES = 200,
  localparam int RW = $clog2(RES_FULL + 1),
  localparam int CW = $clog2(MAX_CUT + 1),
  localparam int WW = $clog2(WIN_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_in,
  input  logic [1:0]          addr_in,
  input  logic                en_in,
  output logic                sdo,
  output logic                conv_start,
  output logic [RW-1:0]       conv_res,
  output logic [1:0]          conv_chan,
  input  logic                conv_done,
  input  logic [RES_FULL-1:0] conv_result
);

  typedef enum logic [1:0] {S_SLEEP, S_WIN, S_WAIT, S_SHIFT} st_t;

  st_t                st;
  logic [2:0]         sck_q;
  logic [1:0]         en_q;
  logic [1:0]         a_q0, a_q1;
  logic [WW-1:0]      win;
  logic [CW-1:0]      cut;
  logic [RW-1:0]      cnt;
  logic [RES_FULL-1:0] sh;
  logic [1:0]         chan;
  logic               sdo_q, start_q;

  wire fall     = sck_q[2] & ~sck_q[1];
  wire en_ok    = en_q[1];
  wire busy     = (st == S_WIN) || (st == S_WAIT);
  wire shifting = (st == S_SHIFT);

  assign conv_res   = RW'(RES_FULL) - RW'(cut);
  assign conv_chan  = chan;
  assign conv_start = start_q;
  assign sdo        = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= '1;
      en_q    <= '0;
      a_q0    <= '0;
      a_q1    <= '0;
      st      <= S_SLEEP;
      win     <= '0;
      cut     <= '0;
      cnt     <= '0;
      sh      <= '0;
      chan    <= '0;
      sdo_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sck_q   <= {sck_q[1:0], sck_in};
      en_q    <= {en_q[0], en_in};
      a_q0    <= addr_in;
      a_q1    <= a_q0;
      start_q <= 1'b0;
      if (!en_ok) begin
        st    <= S_SLEEP;
        sdo_q <= 1'b0;
      end else begin
        case (st)
          S_SLEEP: if (fall) begin
            chan <= a_q1;
            cut  <= '0;
            win  <= '0;
            st   <= S_WIN;
          end
          S_WIN: begin
            if (fall && cut < CW'(MAX_CUT)) cut <= cut + CW'(1);
            if (win == WW'(WIN_CYCLES - 1)) begin
              start_q <= 1'b1;
              st      <= S_WAIT;
            end else begin
              win <= win + WW'(1);
            end
          end
          S_WAIT: if (conv_done) begin
            sh  <= conv_result;
            cnt <= '0;
            st  <= S_SHIFT;
          end
          S_SHIFT: if (fall) begin
            if (cnt == conv_res) begin
              sdo_q <= 1'b0;
              st    <= S_SLEEP;
            end else begin
              sdo_q <= sh[RES_FULL-1];
              sh    <= sh << 1;
              cnt   <= cnt + RW'(1);
            end
          end
          default: st <= S_SLEEP;
        endcase
      end
    end
  end

endmodule

// File: rtl/sadc_front_chk.sv
module sadc_front_chk #(
  parameter int RES_FULL = 16,
  parameter int MAX_CUT  = 6,
  parameter int RW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_ok,
  input logic          busy,
  input logic          shifting,
  input logic          sdo,
  input logic          conv_start,
  input logic [RW-1:0] conv_res,
  input logic [1:0]    conv_chan
);

  p_busy_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sdo);

  p_res_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_res >= RW'(RES_FULL - MAX_CUT)) && (conv_res <= RW'(RES_FULL)));

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> (!sdo && !busy && !shifting));

  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(conv_chan));

endmodule

bind sadc_front sadc_front_chk #(.RES_FULL(RES_FULL), .MAX_CUT(MAX_CUT), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .busy(busy), .shifting(shifting),
  .sdo(sdo), .conv_start(conv_start), .conv_res(conv_res), .conv_chan(conv_chan)
);

// File: tb/test_sadc_front.sv
module test_sadc_front;
  localparam int LAT = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sck = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic        en = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] conv_result = '0;
  logic        sdo, conv_start;
  logic [4:0]  conv_res;
  logic [1:0]  conv_chan;

  sadc_front i_sadc_front (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .addr_in(addr), .en_in(en),
    .sdo(sdo), .conv_start(conv_start), .conv_res(conv_res), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  int checks = 0, fails = 0;
  int st_seen = 0, done_seen = 0;
  logic [4:0] got_res;
  logic [1:0] got_chan;
  bit    exp_q[$];
  string tag_q[$];
  event  bit_ready;

  function automatic logic [15:0] model(input logic [1:0] c);
    return {c, ~c, 12'hB4D};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // converter stub
  initial forever begin
    @(posedge clk);
    if (conv_start === 1'b1) begin
      st_seen++;
      got_res  = conv_res;
      got_chan = conv_chan;
      repeat (LAT) @(posedge clk);
      conv_result <= model(got_chan);
      conv_done   <= 1'b1;
      @(posedge clk);
      conv_done   <= 1'b0;
      done_seen++;
    end
  end

  // monitor: compare each shifted bit with the scoreboard
  initial forever begin
    @(bit_ready);
    if (exp_q.size() > 0) chk(tag_q.pop_front(), sdo, exp_q.pop_front());
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic sck_edge();
    @(negedge clk) sck = 1'b0;
    repeat (8) @(negedge clk);
    sck = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // start, pick resolution, wait for result; returns expected resolution
  task automatic convert(input logic [1:0] a, input int n, input int late, output int res);
    int s0, d0;
    @(negedge clk) addr = a;
    repeat (4) @(negedge clk);
    s0 = st_seen; d0 = done_seen;
    sck_edge();
    chk("R5 busy in window", sdo, 0);
    for (int i = 0; i < n; i++) sck_edge();
    while (st_seen == s0) @(negedge clk);
    res = 16 - ((n > 6) ? 6 : n);
    chk("R3/R9 resolution", got_res, res);
    chk("R2 channel", got_chan, a);
    for (int i = 0; i < late; i++) sck_edge();
    chk("R5 busy while waiting", sdo, 0);
    while (done_seen == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R5 low before readout", sdo, 0);
  endtask

  task automatic readout(input logic [1:0] a, input int res, input int nread, input bit tail);
    logic [15:0] w = model(a);
    for (int i = 0; i < nread; i++) begin
      exp_q.push_back(w[15-i]);
      tag_q.push_back("R6 data bit");
      sck_edge();
      -> bit_ready;
    end
    if (tail) begin
      exp_q.push_back(1'b0);
      tag_q.push_back("R7 low after last bit");
      sck_edge();
      -> bit_ready;
    end
    @(negedge clk);
  endtask

  initial begin
    int res, s0;
    repeat (5) @(negedge clk);
    chk("R10 sdo after reset", sdo, 0);
    chk("R10 start after reset", conv_start, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: enable low, edges start nothing
    s0 = st_seen;
    sck_edge();
    repeat (300) @(negedge clk);
    chk("R1 no start while disabled", st_seen, s0);

    en = 1'b1;
    repeat (5) @(negedge clk);

    convert(2'b00, 0, 0, res); readout(2'b00, res, res, 1);
    convert(2'b01, 3, 0, res); readout(2'b01, res, res, 1);
    convert(2'b10, 6, 0, res); readout(2'b10, res, res, 1);
    convert(2'b11, 7, 0, res); readout(2'b11, res, res, 1);

    // R4: late edges before done are ignored
    convert(2'b01, 0, 2, res);
    chk("R4 resolution kept", got_res, 16);
    readout(2'b01, res, res, 1);

    // R8: abort in mid readout
    convert(2'b10, 2, 0, res);
    readout(2'b10, res, 5, 0);
    @(negedge clk) en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 sdo low on abort", sdo, 0);
    en = 1'b1;
    repeat (4) @(negedge clk);
    s0 = st_seen;
    sck_edge();
    chk("R8 sdo low after resume", sdo, 0);
    while (st_seen == s0) @(negedge clk);
    chk("R8/R1 new start after abort", st_seen, s0 + 1);
    chk("R8 resolution on restart", got_res, 16);
    repeat (LAT + 10) @(negedge clk);
    readout(2'b10, 16, 16, 1);

    repeat (20) @(negedge clk);
    chk("R7 idle sdo", sdo, 0);
    finish_run();
  end
endmodule